// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block is the I/O-mapped control face of a two-channel bus-master DMA unit. Software reaches it through byte-enabled 32-bit I/O reads and writes. The block claims only those bytes that fall in a 16-byte window at a base address that configuration space supplies, and only while configuration I/O decoding is enabled. Each channel owns an 8-byte slice of the window, selected by offset bit 3. A slice holds a command byte at offset 0, a status byte at offset 2 and a 32-bit descriptor table pointer at offsets 4 to 7.

Each channel's DMA engine receives three things from the block: a run level, a transfer direction and a one-cycle start pulse, which tells the engine to clear its byte count and end-of-table flag. A pointer-load pulse tells the engine to take the pointer value as its current address. In return, the engine reports a done event, which clears the active flag, and the drive reports an interrupt request. The interrupt request is latched as a status flag and is also passed straight through to the channel's interrupt output.

Each byte lane of an access is decoded on its own at address port+lane, so one unaligned dword can touch several registers, or both channels, at once. Read data and the acknowledge are registered.

Top module: `dma_chan_regs`

## Requirements
- R1: A byte lane is claimed only when the window-aligned base (cfg_base with bits 3..0 cleared) is nonzero, cfg_io_en is 1, and the lane address lies in [base, base+16). An unclaimed lane changes no register and reads as 0x00. io_ack is 1 in the cycle after an access in which at least one enabled lane was claimed, and 0 otherwise.
- R2: Offset bit 3 selects the channel (0 or 1). Offset 0 is the command byte, offset 2 the status byte, and offsets 4..7 are pointer bytes 0..3. Offsets 1 and 3 read as 0x00 and ignore writes.
- R3: Command bits 7..4, 2 and 1 always read 0. eng_run[ch] equals command bit 0, and eng_dir[ch] equals command bit 3 (1 = device to memory). Both update at the clock edge of the write.
- R4: A command write that takes bit 0 from 0 to 1 raises eng_start[ch] for exactly one cycle, from the edge of the write. Writing 1 while bit 0 is already 1, or writing 0, gives no pulse.
- R5: A command write copies its bit 0 into status bit 0 (active). A status write never changes status bit 0.
- R6: In the status byte, bits 7, 4 and 3 read 0. Bits 6 and 5 are plain read/write. Bits 2 and 1 are cleared by writing 1 and kept by writing 0.
- R7: A 0→1 change of drv_irq[ch] sets status bit 2 at the next edge, and this set wins over a write-one-to-clear in the same cycle. irq_out[ch] equals drv_irq[ch] in the same cycle.
- R8: eng_done[ch] clears status bit 0 at the next edge. It takes priority over a command write in the same cycle that sets bit 0, and it leaves the command byte unchanged.
- R9: Pointer bytes are written one at a time under their byte enables, and pointer bits 1..0 always read 0. eng_ptr shows the stored pointer, and eng_ptr_load[ch] is high for one cycle after any write to that channel's pointer bytes.
- R10: io_rdata is registered in the cycle after io_rd. Each byte lane carries the register at port+lane when that lane is enabled and claimed, and 0x00 otherwise. Lanes of one access act in parallel, even across registers or channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write strobe, one cycle |
| io_rd | input | 1 | I/O read strobe, one cycle |
| io_addr | input | 16 | I/O port address of lane 0 |
| io_be | input | 4 | Byte enables, lane l at io_addr+l |
| io_wdata | input | 32 | Write data, lane l in bits 8l+7..8l |
| io_rdata | output | 32 | Registered read data |
| io_ack | output | 1 | Registered: previous access claimed a lane |
| cfg_base | input | 16 | Window base from configuration space |
| cfg_io_en | input | 1 | Configuration I/O decode enable |
| eng_done | input | 2 | Per channel: transfer finished, clear active |
| drv_irq | input | 2 | Per channel drive interrupt request |
| eng_run | output | 2 | Per channel run level (command bit 0) |
| eng_dir | output | 2 | Per channel direction (command bit 3) |
| eng_start | output | 2 | Per channel one-cycle start pulse |
| eng_ptr_load | output | 2 | Per channel one-cycle pointer-load pulse |
| eng_ptr | output | 64 | Channel pointers, channel 1 in bits 63..32 |
| irq_out | output | 2 | Per channel interrupt pass-through |

## Verification
Register state, eng_run, eng_dir, eng_start and eng_ptr_load all change at the edge that samples the write. The bench drives each access at a falling edge, holds it across one rising edge, and checks these outputs at the next falling edge. It checks the pulses again one cycle later to prove they last a single cycle. io_rdata and io_ack belong to the edge that samples io_rd, so the read task returns them at that same falling edge. Interrupt and done events register at the following edge and are then checked by a read. irq_out is combinational and is checked one time step after drv_irq changes.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int REG_BYTES = 8;
  localparam logic [2:0] CMD_OFF  = 3'd0;
  localparam logic [2:0] STS_OFF  = 3'd2;
  localparam int         PTR_BASE = 4;
  // command bit positions
  localparam int CMD_RUN = 0;
  localparam int CMD_DIR = 3;
  // status bit positions
  localparam int STS_ACT = 0;
  localparam int STS_ERR = 1;
  localparam int STS_INT = 2;
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  parameter int NUM_CH = 2,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OFF_W = CH_W + 3,
  localparam int WIN   = 8 << CH_W
) (
  input  logic                      io_wr,
  input  logic [ADDR_W-1:0]         io_addr,
  input  logic [LANES-1:0]          io_be,
  input  logic [LANES*8-1:0]        io_wdata,
  input  logic [ADDR_W-1:0]         cfg_base,
  input  logic                      cfg_io_en,
  output logic [LANES-1:0]          lane_hit,
  output logic [LANES*OFF_W-1:0]    lane_off,
  output logic [NUM_CH*8-1:0]       reg_we,
  output logic [NUM_CH*64-1:0]      reg_wdat
);
  logic [ADDR_W-1:0] base_al;
  logic              base_ok;

  assign base_al = {cfg_base[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign base_ok = (base_al != '0) && cfg_io_en;

  always_comb begin
    lane_hit = '0;
    lane_off = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [ADDR_W-1:0] la;
      logic [ADDR_W:0]   diff;
      la   = io_addr + ADDR_W'(l);
      diff = {1'b0, la} - {1'b0, base_al};
      lane_hit[l] = base_ok && (diff < (ADDR_W+1)'(WIN));
      lane_off[l*OFF_W +: OFF_W] = diff[OFF_W-1:0];
    end
  end

  always_comb begin
    reg_we   = '0;
    reg_wdat = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int r = 0; r < 8; r++) begin
        for (int l = 0; l < LANES; l++) begin
          if (io_wr && io_be[l] && lane_hit[l] &&
              lane_off[l*OFF_W +: OFF_W] == OFF_W'(c*8 + r)) begin
            reg_we[c*8 + r]          = 1'b1;
            reg_wdat[c*64 + r*8 +: 8] = io_wdata[l*8 +: 8];
          end
        end
      end
    end
  end
endmodule

// File: rtl/dcr_channel.sv
module dcr_channel
  import dcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  we,
  input  logic [63:0] wdat,
  input  logic        done,
  input  logic        irq_in,
  output logic        run,
  output logic        dir,
  output logic        start_p,
  output logic        load_p,
  output logic [31:0] ptr,
  output logic [63:0] rbytes
);
  logic [7:0] cmd, sts;
  logic       irq_prev;
  logic [7:0] cmd_wd, sts_wd;
  logic [7:0] cmd_n, sts_n;
  logic [31:0] ptr_n;

  assign cmd_wd = wdat[CMD_OFF*8 +: 8];
  assign sts_wd = wdat[STS_OFF*8 +: 8];

  always_comb begin
    cmd_n = cmd;
    if (we[CMD_OFF]) begin
      cmd_n = '0;
      cmd_n[CMD_RUN] = cmd_wd[CMD_RUN];
      cmd_n[CMD_DIR] = cmd_wd[CMD_DIR];
    end
  end

  always_comb begin
    sts_n = sts;
    if (we[STS_OFF]) begin
      sts_n[6:5] = sts_wd[6:5];
      if (sts_wd[STS_INT]) sts_n[STS_INT] = 1'b0;
      if (sts_wd[STS_ERR]) sts_n[STS_ERR] = 1'b0;
    end
    if (we[CMD_OFF]) sts_n[STS_ACT] = cmd_wd[CMD_RUN];
    if (irq_in && !irq_prev) sts_n[STS_INT] = 1'b1;
    if (done) sts_n[STS_ACT] = 1'b0;
  end

  always_comb begin
    ptr_n = ptr;
    for (int b = 0; b < 4; b++)
      if (we[PTR_BASE + b]) ptr_n[b*8 +: 8] = wdat[(PTR_BASE + b)*8 +: 8];
    ptr_n[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd      <= '0;
      sts      <= '0;
      ptr      <= '0;
      irq_prev <= 1'b0;
      start_p  <= 1'b0;
      load_p   <= 1'b0;
    end else begin
      cmd      <= cmd_n;
      sts      <= sts_n;
      ptr      <= ptr_n;
      irq_prev <= irq_in;
      start_p  <= we[CMD_OFF] && cmd_wd[CMD_RUN] && !cmd[CMD_RUN];
      load_p   <= |we[PTR_BASE +: 4];
    end
  end

  assign run = cmd[CMD_RUN];
  assign dir = cmd[CMD_DIR];

  always_comb begin
    rbytes = '0;
    rbytes[CMD_OFF*8 +: 8]  = cmd;
    rbytes[STS_OFF*8 +: 8]  = sts;
    rbytes[PTR_BASE*8 +: 32] = ptr;
  end

  // R4
  start_edge_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |-> (run && !$past(run)));
  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_p |=> !start_p);
  // R8
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !rbytes[STS_OFF*8 + STS_ACT]);
  // R7
  irq_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_in && !$past(irq_in)) |=> rbytes[STS_OFF*8 + STS_INT]);
  // R3
  cmd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rbytes[7:4] == 4'd0 && rbytes[2:1] == 2'd0);
  // R9
  ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
    ptr[1:0] == 2'b00);
  // R6
  sts_zero_chk: assert property (@(posedge clk) disable iff (rst)
    sts[7] == 1'b0 && sts[4:3] == 2'b00);
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4,
  parameter int NUM_CH = 2,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int OFF_W = CH_W + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [LANES-1:0]     io_be,
  input  logic [LANES*8-1:0]   io_wdata,
  output logic [LANES*8-1:0]   io_rdata,
  output logic                 io_ack,
  input  logic [ADDR_W-1:0]    cfg_base,
  input  logic                 cfg_io_en,
  input  logic [NUM_CH-1:0]    eng_done,
  input  logic [NUM_CH-1:0]    drv_irq,
  output logic [NUM_CH-1:0]    eng_run,
  output logic [NUM_CH-1:0]    eng_dir,
  output logic [NUM_CH-1:0]    eng_start,
  output logic [NUM_CH-1:0]    eng_ptr_load,
  output logic [NUM_CH*32-1:0] eng_ptr,
  output logic [NUM_CH-1:0]    irq_out
);
  logic [LANES-1:0]       lane_hit;
  logic [LANES*OFF_W-1:0] lane_off;
  logic [NUM_CH*8-1:0]    reg_we;
  logic [NUM_CH*64-1:0]   reg_wdat;
  logic [63:0]            rb_all [NUM_CH];
  logic [LANES*8-1:0]     rdata_n;

  dcr_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .NUM_CH(NUM_CH)) u_dec (
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_be     (io_be),
    .io_wdata  (io_wdata),
    .cfg_base  (cfg_base),
    .cfg_io_en (cfg_io_en),
    .lane_hit  (lane_hit),
    .lane_off  (lane_off),
    .reg_we    (reg_we),
    .reg_wdat  (reg_wdat)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcr_channel u_ch (
      .clk     (clk),
      .rst     (rst),
      .we      (reg_we[c*8 +: 8]),
      .wdat    (reg_wdat[c*64 +: 64]),
      .done    (eng_done[c]),
      .irq_in  (drv_irq[c]),
      .run     (eng_run[c]),
      .dir     (eng_dir[c]),
      .start_p (eng_start[c]),
      .load_p  (eng_ptr_load[c]),
      .ptr     (eng_ptr[c*32 +: 32]),
      .rbytes  (rb_all[c])
    );
  end

  assign irq_out = drv_irq;

  always_comb begin
    rdata_n = '0;
    for (int l = 0; l < LANES; l++) begin
      logic [OFF_W-1:0] off;
      off = lane_off[l*OFF_W +: OFF_W];
      if (io_rd && io_be[l] && lane_hit[l] && int'(off[OFF_W-1:3]) < NUM_CH)
        rdata_n[l*8 +: 8] = rb_all[off[OFF_W-1:3]][off[2:0]*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= '0;
      io_ack   <= 1'b0;
    end else begin
      io_rdata <= rdata_n;
      io_ack   <= (io_wr || io_rd) && |(io_be & lane_hit);
    end
  end

  // R1
  no_claim_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_io_en |=> !io_ack);
  // R10
  idle_read_chk: assert property (@(posedge clk) disable iff (rst)
    !io_rd |=> io_rdata == '0);
endmodule

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic        clk = 0;
  logic        rst;
  logic        io_wr, io_rd;
  logic [15:0] io_addr;
  logic [3:0]  io_be;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata;
  logic        io_ack;
  logic [15:0] cfg_base;
  logic        cfg_io_en;
  logic [1:0]  eng_done, drv_irq;
  logic [1:0]  eng_run, eng_dir, eng_start, eng_ptr_load, irq_out;
  logic [63:0] eng_ptr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  localparam logic [15:0] B = 16'hC000;

  always #5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .cfg_base(cfg_base), .cfg_io_en(cfg_io_en), .eng_done(eng_done),
    .drv_irq(drv_irq), .eng_run(eng_run), .eng_dir(eng_dir),
    .eng_start(eng_start), .eng_ptr_load(eng_ptr_load), .eng_ptr(eng_ptr),
    .irq_out(irq_out)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic io_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    io_wr = 1; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_wr = 0; io_be = 0; io_wdata = 0;
  endtask

  task automatic io_read(input logic [15:0] a, input logic [3:0] be,
                         output logic [31:0] d, output logic ack);
    io_rd = 1; io_addr = a; io_be = be;
    @(negedge clk);
    d = io_rdata; ack = io_ack;
    io_rd = 0; io_be = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic k;
    chk("R3 reset run", {62'd0, eng_run}, 0);
    chk("R9 reset ptr", eng_ptr, 0);
    chk("R7 reset irq_out", {62'd0, irq_out}, 0);
    io_read(B, 4'hF, d, k);
    chk("R1 read with base 0", {32'd0, d}, 0);
    chk("R1 ack with base 0", {63'd0, k}, 0);
  endtask

  task automatic t_decode;
    logic [31:0] d; logic k;
    cfg_base = 16'h0000; cfg_io_en = 1;
    io_write(B, 4'h1, 32'h09);
    cfg_base = B; cfg_io_en = 0;
    io_write(B, 4'h1, 32'h01);
    chk("R1 io disabled write ignored", {63'd0, eng_run[0]}, 0);
    cfg_io_en = 1;
    io_write(B + 16'h10, 4'h1, 32'h01);
    chk("R1 outside window ignored", {62'd0, eng_run}, 0);
    io_read(B + 16'h10, 4'hF, d, k);
    chk("R1 outside read ack", {63'd0, k}, 0);
    chk("R1 outside read data", {32'd0, d}, 0);
    io_read(B, 4'hF, d, k);
    chk("R1 window read ack", {63'd0, k}, 1);
    chk("R1 earlier writes had no effect", {32'd0, d}, 0);
  endtask

  task automatic t_cmd;
    logic [31:0] d; logic k;
    io_write(B, 4'h1, 32'hFF);
    chk("R4 start pulse", {62'd0, eng_start}, 2'b01);
    chk("R3 run", {62'd0, eng_run}, 2'b01);
    chk("R3 dir", {62'd0, eng_dir}, 2'b01);
    @(negedge clk);
    chk("R4 pulse one cycle", {62'd0, eng_start}, 0);
    io_read(B, 4'h1, d, k);
    chk("R3 cmd forced bits", {32'd0, d}, 32'h09);
    io_read(B, 4'h4, d, k);
    chk("R5 active follows start", {32'd0, d}, 32'h0001_0000);
    io_write(B, 4'h1, 32'h01);
    chk("R4 no pulse when already running", {62'd0, eng_start}, 0);
    io_write(B, 4'h1, 32'h08);
    chk("R4 no pulse on stop", {62'd0, eng_start}, 0);
    chk("R3 stop run", {62'd0, eng_run}, 0);
    io_read(B + 16'h2, 4'h1, d, k);
    chk("R5 active cleared by stop", {32'd0, d}, 0);
    io_write(B, 4'h1, 32'h01);
    chk("R4 restart pulse", {62'd0, eng_start}, 2'b01);
  endtask

  task automatic t_sts;
    logic [31:0] d; logic k;
    io_write(B, 4'h4, 32'h00FE_0000);
    io_read(B + 16'h2, 4'h1, d, k);
    chk("R6 plain bits set, reserved zero, active kept", {32'd0, d}, 32'h61);
    io_write(B + 16'h2, 4'h1, 32'h00);
    io_read(B + 16'h2, 4'h1, d, k);
    chk("R5 software cannot clear active", {32'd0, d}, 32'h01);
  endtask

  task automatic t_irq;
    logic [31:0] d; logic k;
    drv_irq = 2'b10; #1;
    chk("R7 irq pass-through", {62'd0, irq_out}, 2'b10);
    @(negedge clk);
    io_read(B + 16'h8, 4'h4, d, k);
    chk("R7 rise sets bit 2", {32'd0, d}, 32'h0004_0000);
    io_write(B + 16'hA, 4'h1, 32'h04);
    io_read(B + 16'hA, 4'h1, d, k);
    chk("R6 write one clears bit 2", {32'd0, d}, 0);
    drv_irq = 2'b00; #1;
    chk("R7 pass-through low", {62'd0, irq_out}, 0);
    @(negedge clk);
    drv_irq = 2'b10;
    @(negedge clk);
    io_write(B + 16'hA, 4'h1, 32'h00);
    io_read(B + 16'hA, 4'h1, d, k);
    chk("R6 write zero keeps bit 2", {32'd0, d}, 32'h04);
    drv_irq = 2'b00;
    io_write(B + 16'hA, 4'h1, 32'h04);
    drv_irq = 2'b10;
    io_write(B + 16'hA, 4'h1, 32'h04);
    io_read(B + 16'hA, 4'h1, d, k);
    chk("R7 set wins over clear", {32'd0, d}, 32'h04);
    drv_irq = 2'b00;
    io_write(B + 16'hA, 4'h1, 32'h04);
  endtask

  task automatic t_done;
    logic [31:0] d; logic k;
    eng_done = 2'b01;
    @(negedge clk);
    eng_done = 2'b00;
    io_read(B + 16'h2, 4'h1, d, k);
    chk("R8 done clears active", {32'd0, d}, 0);
    chk("R8 done keeps run", {62'd0, eng_run}, 2'b01);
    io_write(B, 4'h1, 32'h00);
    eng_done = 2'b01;
    io_write(B, 4'h1, 32'h01);
    eng_done = 2'b00;
    chk("R4 pulse alongside done", {62'd0, eng_start}, 2'b01);
    io_read(B + 16'h2, 4'h1, d, k);
    chk("R8 done beats command write", {32'd0, d}, 0);
  endtask

  task automatic t_ptr;
    logic [31:0] d; logic k;
    io_write(B + 16'h4, 4'hF, 32'h1234_5677);
    chk("R9 load pulse", {62'd0, eng_ptr_load}, 2'b01);
    chk("R9 pointer aligned", {32'd0, eng_ptr[31:0]}, 32'h1234_5674);
    @(negedge clk);
    chk("R9 load pulse one cycle", {62'd0, eng_ptr_load}, 0);
    io_read(B + 16'h4, 4'hF, d, k);
    chk("R9 pointer readback", {32'd0, d}, 32'h1234_5674);
    io_write(B + 16'h4, 4'h2, 32'h0000_AB00);
    chk("R9 single byte write", {32'd0, eng_ptr[31:0]}, 32'h1234_AB74);
    io_write(B + 16'hC, 4'hF, 32'hFFFF_FFFF);
    chk("R2 channel 1 pointer", eng_ptr, 64'hFFFF_FFFC_1234_AB74);
  endtask

  task automatic t_lanes;
    logic [31:0] d; logic k;
    io_write(B + 16'h2, 4'hF, 32'h5566_0060);
    chk("R10 unaligned lanes reach pointer", {32'd0, eng_ptr[31:0]}, 32'h1234_5564);
    io_read(B, 4'hF, d, k);
    chk("R2 dword cmd/unused/status/unused", {32'd0, d}, 32'h0060_0001);
    io_read(B + 16'h4, 4'h1, d, k);
    chk("R10 disabled lanes read zero", {32'd0, d}, 32'h64);
    io_write(B + 16'hE, 4'hF, 32'hAABB_CCDD);
    chk("R1 ack when part of access claimed", {63'd0, io_ack}, 1);
    chk("R10 window edge lanes", eng_ptr[63:32], 32'hCCDD_FFFC);
    io_read(B + 16'hE, 4'hF, d, k);
    chk("R10 lanes beyond window read zero", {32'd0, d}, 32'h0000_CCDD);
  endtask

  initial begin
    rst = 1; io_wr = 0; io_rd = 0; io_addr = 0; io_be = 0; io_wdata = 0;
    cfg_base = 0; cfg_io_en = 0; eng_done = 0; drv_irq = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_decode;
    t_cmd;
    t_sts;
    t_irq;
    t_done;
    t_ptr;
    t_lanes;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule